// File: doc/BRIEF.md
# Serial Request Packet Validity Checker

This block screens each incoming logical-layer request of a serial packet endpoint before the request reaches the read and write engines. The header has already been decoded into fields: priority, format type, transaction type, size, word pointer and address. The checker receives these fields together with the payload byte count and a CRC-good flag, all qualified by a single valid strobe. It returns one verdict per packet: accepted, unsupported, illegal, or pass-through. It also says whether the response builder must send an error response for that packet.

Format types 2, 5 and 6 are handled by the local logical modules. A packet with a good CRC and any other format type goes to a user pass-through stream, and no further checks are applied to it. A software-owned capability mask enables each operation separately. A bank of address windows decides which addresses the endpoint maps. Each window has a base, a mask and an enable. The verdict is registered and appears one clock after the strobe.

Top module: `rio_req_screen`

## Requirements
- R1: After reset all five outputs are 0. One clock after in_valid is high, exactly one of vd_accept, vd_unsup, vd_illegal and vd_pass is 1. One clock after a cycle with in_valid low, all five outputs are 0.
- R2: A packet whose format type is not 2, 5 or 6 gives vd_pass when in_crc_ok is 1, whatever its other fields hold. It gives vd_illegal with err_resp 0 when in_crc_ok is 0. For format types 2, 5 and 6 the CRC flag has no effect.
- R3: Operations map to capability bits as follows. Format 2 with ttype 4 is a read (bit 0). Format 2 with ttype 12 to 15 is a read-side atomic (bit 1). Format 5 with ttype 4 is a write (bit 2) and ttype 5 is a write with response (bit 3). Format 5 with ttype 12 to 14 is a write-side atomic (bit 4). Format 6 with any ttype is a streaming write (bit 5). An operation whose bit is 0 gives vd_unsup. Any other ttype within formats 2 and 5 always gives vd_unsup. Unsupported outranks illegal, and vd_unsup never raises err_resp.
- R4: A supported request with priority 3 gives vd_illegal.
- R5: A write, write-with-response or streaming write with a payload count of 0 gives vd_illegal.
- R6: For a write or a write with response, the size/word-pointer pair is reserved when size > 8, or when size = 3 with word pointer 1. A reserved pair gives vd_illegal.
- R7: Window i hits when its enable is 1 and (address AND mask) equals its base. A read, write, write with response or streaming write that hits no window gives vd_illegal. Atomics skip the window check.
- R8: A read with a nonzero payload count gives vd_illegal. A read whose size is below 3 (less than one full 8-byte transfer) or whose pair is reserved also gives vd_illegal.
- R9: For a write or a write with response, the payload count must equal 2^size bytes. Any other count gives vd_illegal.
- R10: err_resp is 1 only together with vd_illegal, and only for a read, a write with response, or a write-side atomic. Illegal writes, streaming writes, read-side atomics and CRC-bad foreign packets give err_resp 0.
- R11: A supported request that breaks no rule gives vd_accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Packet fields valid this cycle |
| in_prio | input | 2 | Request priority |
| in_ftype | input | 4 | Format type |
| in_ttype | input | 4 | Transaction type |
| in_size | input | 4 | Read or write size code |
| in_wdptr | input | 1 | Word pointer |
| in_addr | input | ADDR_W | Target address |
| in_len | input | LEN_W | Payload byte count |
| in_crc_ok | input | 1 | Packet CRC was good |
| cap_mask | input | 6 | Operation enable bits (see R3) |
| win_base | input | NWIN*ADDR_W | Window bases, window i at slice i |
| win_mask | input | NWIN*ADDR_W | Window masks, window i at slice i |
| win_en | input | NWIN | Window enables |
| vd_accept | output | 1 | Request accepted |
| vd_unsup | output | 1 | Unsupported transaction |
| vd_illegal | output | 1 | Illegal decode |
| vd_pass | output | 1 | Routed to pass-through stream |
| err_resp | output | 1 | Error response required |

## Verification
The hardest cases to reach are the ones where several rules fire at once and the verdict depends on which one ranks first. Examples are a priority-3 packet that is also foreign or disabled, and a read that fails only on a window that is configured but switched off. The stimulus reprograms the capability mask and the window enables between packets. It then sends packets built to break exactly one rule, or two rules at different ranks. Back-to-back strobes and idle gaps between them show that each verdict lasts one cycle and belongs to the right packet.

// File: rtl/rio_screen_pkg.sv
package rio_screen_pkg;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_ATOM_R  = 3'd1,
    OP_WRITE   = 3'd2,
    OP_WRITE_R = 3'd3,
    OP_ATOM_W  = 3'd4,
    OP_STREAM  = 3'd5,
    OP_RSVD    = 3'd6,
    OP_FOREIGN = 3'd7
  } op_e;

  localparam int NOPS = 6;

  typedef struct packed {
    logic accept;
    logic unsup;
    logic illegal;
    logic pass;
    logic resp;
  } verdict_t;

endpackage

// File: rtl/rio_op_decode.sv
module rio_op_decode
  import rio_screen_pkg::*;
(
  input  logic [3:0] ftype,
  input  logic [3:0] ttype,
  output op_e        op
);

  always_comb begin
    op = OP_FOREIGN;
    case (ftype)
      4'd2: begin
        if (ttype == 4'd4)       op = OP_READ;
        else if (ttype >= 4'd12) op = OP_ATOM_R;
        else                     op = OP_RSVD;
      end
      4'd5: begin
        if (ttype == 4'd4)                          op = OP_WRITE;
        else if (ttype == 4'd5)                     op = OP_WRITE_R;
        else if (ttype >= 4'd12 && ttype <= 4'd14)  op = OP_ATOM_W;
        else                                        op = OP_RSVD;
      end
      4'd6:    op = OP_STREAM;
      default: op = OP_FOREIGN;
    endcase
  end

endmodule

// File: rtl/rio_win_match.sv
module rio_win_match #(
  parameter int ADDR_W = 32,
  parameter int NWIN   = 4
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NWIN*ADDR_W-1:0] base,
  input  logic [NWIN*ADDR_W-1:0] mask,
  input  logic [NWIN-1:0]        en,
  output logic                   hit
);

  logic [NWIN-1:0] hit_vec;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign hit_vec[g] = en[g] &&
      ((addr & mask[g*ADDR_W +: ADDR_W]) == base[g*ADDR_W +: ADDR_W]);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/rio_rule_check.sv
module rio_rule_check
  import rio_screen_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  op_e              op,
  input  logic [1:0]       prio,
  input  logic [3:0]       size,
  input  logic             wdptr,
  input  logic [LEN_W-1:0] len,
  input  logic             win_hit,
  output logic             illegal
);

  localparam int BYTES_W = LEN_W + 1;

  logic               rsvd_pair;
  logic [BYTES_W-1:0] implied;
  logic               len_zero;
  logic               len_bad;
  logic               field_bad;

  assign rsvd_pair = (size > 4'd8) || ((size == 4'd3) && wdptr);
  assign implied   = BYTES_W'(1) << size;
  assign len_zero  = (len == '0);
  assign len_bad   = ({1'b0, len} != implied);

  always_comb begin
    field_bad = 1'b0;
    case (op)
      OP_READ:             field_bad = !len_zero || (size < 4'd3) || rsvd_pair || !win_hit;
      OP_WRITE, OP_WRITE_R: field_bad = len_zero || rsvd_pair || !win_hit || len_bad;
      OP_STREAM:           field_bad = len_zero || !win_hit;
      default:             field_bad = 1'b0;
    endcase
  end

  assign illegal = (prio == 2'd3) || field_bad;

endmodule

// File: rtl/rio_req_screen.sv
module rio_req_screen
  import rio_screen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 9,
  parameter int NWIN   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             in_prio,
  input  logic [3:0]             in_ftype,
  input  logic [3:0]             in_ttype,
  input  logic [3:0]             in_size,
  input  logic                   in_wdptr,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic [LEN_W-1:0]       in_len,
  input  logic                   in_crc_ok,
  input  logic [NOPS-1:0]        cap_mask,
  input  logic [NWIN*ADDR_W-1:0] win_base,
  input  logic [NWIN*ADDR_W-1:0] win_mask,
  input  logic [NWIN-1:0]        win_en,
  output logic                   vd_accept,
  output logic                   vd_unsup,
  output logic                   vd_illegal,
  output logic                   vd_pass,
  output logic                   err_resp
);

  op_e      op;
  logic     win_hit;
  logic     rule_bad;
  logic [7:0] cap_ext;
  verdict_t v_nxt;
  verdict_t v_q;

  rio_op_decode i_dec (
    .ftype (in_ftype),
    .ttype (in_ttype),
    .op    (op)
  );

  rio_win_match #(.ADDR_W(ADDR_W), .NWIN(NWIN)) i_win (
    .addr (in_addr),
    .base (win_base),
    .mask (win_mask),
    .en   (win_en),
    .hit  (win_hit)
  );

  rio_rule_check #(.LEN_W(LEN_W)) i_rule (
    .op      (op),
    .prio    (in_prio),
    .size    (in_size),
    .wdptr   (in_wdptr),
    .len     (in_len),
    .win_hit (win_hit),
    .illegal (rule_bad)
  );

  assign cap_ext = {{(8-NOPS){1'b0}}, cap_mask};

  // Verdict in rank order: pass-through, unsupported, illegal, accepted
  always_comb begin
    v_nxt = '0;
    if (in_valid) begin
      if (op == OP_FOREIGN) begin
        if (in_crc_ok) v_nxt.pass    = 1'b1;
        else           v_nxt.illegal = 1'b1;
      end else if (op == OP_RSVD || !cap_ext[op]) begin
        v_nxt.unsup = 1'b1;
      end else if (rule_bad) begin
        v_nxt.illegal = 1'b1;
        v_nxt.resp    = (op == OP_READ) || (op == OP_WRITE_R) || (op == OP_ATOM_W);
      end else begin
        v_nxt.accept = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_nxt;
  end

  assign vd_accept  = v_q.accept;
  assign vd_unsup   = v_q.unsup;
  assign vd_illegal = v_q.illegal;
  assign vd_pass    = v_q.pass;
  assign err_resp   = v_q.resp;

endmodule

// File: rtl/rio_req_screen_chk.sv
module rio_req_screen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] in_prio,
  input logic [3:0] in_ftype,
  input logic       in_crc_ok,
  input logic       vd_accept,
  input logic       vd_unsup,
  input logic       vd_illegal,
  input logic       vd_pass,
  input logic       err_resp
);

  logic local_ft;
  assign local_ft = (in_ftype == 4'd2) || (in_ftype == 4'd5) || (in_ftype == 4'd6);

  // R1
  exactly_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $countones({vd_accept, vd_unsup, vd_illegal, vd_pass}) == 1);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> {vd_accept, vd_unsup, vd_illegal, vd_pass, err_resp} == 5'b0);

  // R2
  pass_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_crc_ok && !local_ft) |=> vd_pass);

  // R4
  prio3_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_prio == 2'd3) |=> !vd_accept);

  // R10
  resp_needs_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_resp |-> vd_illegal);

  // R10
  resp_not_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_ftype == 4'd6 || !local_ft)) |=> !err_resp);

endmodule

bind rio_req_screen rio_req_screen_chk i_chk (.*);

// File: tb/test_rio_req_screen.sv
module test_rio_req_screen;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 9;
  localparam int NWIN   = 4;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   in_valid;
  logic [1:0]             in_prio;
  logic [3:0]             in_ftype, in_ttype, in_size;
  logic                   in_wdptr;
  logic [ADDR_W-1:0]      in_addr;
  logic [LEN_W-1:0]       in_len;
  logic                   in_crc_ok;
  logic [5:0]             cap_mask;
  logic [NWIN*ADDR_W-1:0] win_base, win_mask;
  logic [NWIN-1:0]        win_en;
  logic                   vd_accept, vd_unsup, vd_illegal, vd_pass, err_resp;

  always #2 clk = ~clk;

  rio_req_screen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NWIN(NWIN)) i_rio_req_screen (.*);

  typedef struct { logic [4:0] exp; string req; } item_t;
  item_t q[$];
  int checks = 0;
  int fails  = 0;
  logic vld_d = 1'b0;
  bit done = 0;

  // expected vector {accept, unsup, illegal, pass, resp}
  function automatic logic [4:0] model(input logic [1:0] p, input logic [3:0] ft, tt, sz,
                                       input logic wp, input logic [31:0] a,
                                       input logic [8:0] n, input logic crc);
    int kind;   // 0..5 supported op index, -1 reserved, -2 foreign
    bit hit = 0;
    bit bad;
    if (ft == 2)      kind = (tt == 4) ? 0 : (tt >= 12) ? 1 : -1;
    else if (ft == 5) kind = (tt == 4) ? 2 : (tt == 5) ? 3 : (tt >= 12 && tt <= 14) ? 4 : -1;
    else if (ft == 6) kind = 5;
    else              kind = -2;
    if (kind == -2) return crc ? 5'b00010 : 5'b00100;
    if (kind == -1 || !cap_mask[kind]) return 5'b01000;
    for (int i = 0; i < NWIN; i++)
      if (win_en[i] && ((a & win_mask[i*32 +: 32]) == win_base[i*32 +: 32])) hit = 1;
    bad = (p == 3);
    if (kind == 0)
      bad |= (n != 0) || (sz < 3) || (sz > 8) || (sz == 3 && wp) || !hit;
    if (kind == 2 || kind == 3)
      bad |= (n == 0) || (sz > 8) || (sz == 3 && wp) || !hit || (sz <= 8 && int'(n) != (1 << sz));
    if (kind == 5)
      bad |= (n == 0) || !hit;
    if (bad) return {2'b00, 1'b1, 1'b0, (kind == 0 || kind == 3 || kind == 4)};
    return 5'b10000;
  endfunction

  task automatic send(input string req, input logic [1:0] p, input logic [3:0] ft, tt, sz,
                      input logic wp, input logic [31:0] a, input logic [8:0] n,
                      input logic crc);
    item_t it;
    @(negedge clk);
    in_valid = 1; in_prio = p; in_ftype = ft; in_ttype = tt; in_size = sz;
    in_wdptr = wp; in_addr = a; in_len = n; in_crc_ok = crc;
    it.exp = model(p, ft, tt, sz, wp, a, n, crc);
    it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  always @(posedge clk) vld_d <= in_valid;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      logic [4:0] got;
      got = {vd_accept, vd_unsup, vd_illegal, vd_pass, err_resp};
      if (vld_d) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s: got %b expected %b", it.req, got, it.exp);
        end
      end else begin
        checks++;
        if (got !== 5'b0) begin
          fails++;
          $display("FAIL R1 idle: got %b expected %b", got, 5'b0);
        end
      end
    end
  end

  task automatic finish_up;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      finish_up();
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_prio = 0; in_ftype = 0; in_ttype = 0; in_size = 0;
    in_wdptr = 0; in_addr = 0; in_len = 0; in_crc_ok = 1; cap_mask = 6'h3F;
    win_base = {32'h0000_4000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000};
    win_mask = {32'hFFFF_C000, 32'hF000_0000, 32'hFFFF_0000, 32'hF000_0000};
    win_en   = 4'b1011;
    repeat (3) @(negedge clk);
    checks++;
    if ({vd_accept, vd_unsup, vd_illegal, vd_pass, err_resp} !== 5'b0) begin
      fails++;
      $display("FAIL R1 reset: got %b expected %b",
               {vd_accept, vd_unsup, vd_illegal, vd_pass, err_resp}, 5'b0);
    end
    rst_n = 1;
    idle(2);

    send("R11 read ok",          0, 2, 4, 3, 0, 32'h1000_0040, 0, 1);
    send("R8 read small size",   0, 2, 4, 1, 0, 32'h1000_0040, 0, 1);
    send("R8 read with payload", 0, 2, 4, 3, 0, 32'h1000_0040, 8, 1);
    send("R6 read rsvd pair",    1, 2, 4, 3, 1, 32'h1000_0040, 0, 1);
    idle(1);
    send("R11 write ok",         0, 5, 4, 3, 0, 32'h2000_0010, 8, 1);
    send("R9 write len short",   0, 5, 4, 3, 0, 32'h2000_0010, 4, 1);
    send("R9 write 256 ok",      2, 5, 4, 8, 1, 32'h2000_0100, 256, 1);
    send("R6 write_r rsvd pair", 0, 5, 5, 3, 1, 32'h2000_0010, 8, 1);
    send("R6 write_r size 9",    0, 5, 5, 9, 0, 32'h2000_0010, 16, 1);
    send("R5 write no payload",  0, 5, 4, 0, 0, 32'h2000_0010, 0, 1);
    send("R11 write_r ok",       1, 5, 5, 2, 0, 32'h1FFF_FFF0, 4, 1);
    idle(2);
    send("R11 stream ok",        0, 6, 0, 0, 0, 32'h0000_4100, 64, 1);
    send("R5 stream no payload", 0, 6, 0, 0, 0, 32'h0000_4100, 0, 1);
    send("R7 read disabled win", 0, 2, 4, 3, 0, 32'h3000_0010, 0, 1);
    send("R7 write mask miss",   0, 5, 4, 3, 0, 32'h2001_0000, 8, 1);
    send("R7 stream miss",       0, 6, 0, 0, 0, 32'h0000_8000, 8, 1);
    send("R4 write prio3",       3, 5, 4, 3, 0, 32'h2000_0010, 8, 1);
    send("R4 atom_w prio3",      3, 5, 12, 0, 0, 32'h0, 0, 1);
    send("R4 atom_r prio3",      3, 2, 13, 0, 0, 32'h0, 0, 1);
    send("R11 atom_w no win",    0, 5, 14, 0, 0, 32'hFFFF_0000, 4, 1);
    idle(1);
    @(negedge clk); win_en = 4'b1111; in_valid = 0;
    send("R7 window enabled",    0, 2, 4, 3, 0, 32'h3000_0010, 0, 1);
    @(negedge clk); cap_mask = 6'b111011; in_valid = 0;
    send("R3 write disabled",    0, 5, 4, 3, 0, 32'h2000_0010, 8, 1);
    send("R3 disabled prio3",    3, 5, 4, 3, 0, 32'h2000_0010, 0, 1);
    send("R3 rsvd ttype",        0, 5, 7, 3, 0, 32'h2000_0010, 8, 1);
    send("R3 rsvd ttype f2",     0, 2, 0, 3, 0, 32'h1000_0000, 0, 1);
    send("R10 write_r still ok", 0, 5, 5, 3, 0, 32'h2000_0010, 8, 1);
    @(negedge clk); cap_mask = 6'h3F; in_valid = 0;
    send("R2 foreign pass",      3, 8, 0, 15, 1, 32'h0, 0, 1);
    send("R2 foreign crc bad",   0, 8, 0, 0, 0, 32'h0, 0, 0);
    send("R2 local crc bad",     0, 2, 4, 3, 0, 32'h1000_0040, 0, 0);
    send("R2 ftype 13 pass",     0, 13, 4, 3, 0, 32'h1000_0040, 8, 1);
    idle(3);
    finish_up();
  end

endmodule